// File: doc/BRIEF.md
# Bus-Mapped Watchdog Timer

This block is a watchdog timer that software reaches through an APB-style register port. A 32-bit counter runs down from a programmable reload value. Software must keep restarting it by writing one fixed key value. If software stops doing this, the counter reaches zero. The block then latches a sticky status flag and sends a pulse on its system-reset, interrupt and external-signal outputs. Each of these three outputs has its own enable, and all three share one programmable pulse width. After an expiry the counter reloads and keeps running.

The counter can decrement once per bus clock, or once per rising edge of a slower external clock. The external clock is brought into the bus clock domain through a two-stage synchronizer. An edge detector after the synchronizer turns each rising edge into a single-cycle count enable. A bus write is accepted in the cycle where select, enable and write are all high. Reads return data combinationally from the addressed register. The word index is paddr[4:2].

Top module: `wdog_apb_top`

## Requirements
- R1: After reset these registers read as follows: reload (offset 0x04) reads 0x03EF1480, count (offset 0x00) reads 0x03EF1480, pulse length (offset 0x18) reads 0xFF, control (offset 0x0C) reads 0, and status (offset 0x10) reads 0. All three outputs are low.
- R2: The counter runs when control bit 0 is 1 and control bit 4 is 0. In that mode it decrements once per bus clock. The tick that finds the count at zero is the expiry. It comes reload+1 cycles after the control write that starts the count.
- R3: A write of exactly 0x5AB9 to offset 0x08 copies the reload value into the counter. A write of any other value to that offset leaves the count unchanged.
- R4: Status bit 0 is set on expiry and stays set. A write with bit 0 = 1 to offset 0x14 clears it. A write with bit 0 = 0 to that offset leaves it set.
- R5: On expiry each enabled output goes high for exactly (pulse length + 1) bus cycles. The counter reloads at expiry, so expiries repeat every reload+1 cycles.
- R6: Control bit 1 enables the reset output, bit 2 the interrupt output and bit 3 the external-signal output. A disabled output stays low through an expiry.
- R7: A control write with bit 0 = 0 freezes the count at its current value. It also drives all three outputs low from the next cycle.
- R8: When control bit 4 is 1, the counter decrements once per rising edge of ext_clk, whose period is more than two bus cycles. It does not decrement while ext_clk stays constant.
- R9: The pulse length (8 bits, offset 0x18), the reload value (offset 0x04) and control bits [4:0] (offset 0x0C) read back the values last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 5 | Byte address; bits [4:2] select the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| ext_clk | input | 1 | Slow external count clock, asynchronous to pclk |
| wdog_reset_o | output | 1 | Expiry pulse toward system reset |
| wdog_irq_o | output | 1 | Expiry pulse toward the interrupt controller |
| wdog_sig_o | output | 1 | Expiry pulse toward an external pin |

## Verification
The hardest situation to reach from the ports is a clean view of the pulse width. Successive expiries come back every reload+1 cycles, so a pulse longer than that period merges into the next one. The bench sweeps small reload values and, for each one, every pulse length below it. Each pass restarts the counter while it is frozen and then starts it with a control write. This lets the bench count the exact delay to the first pulse, the pulse width and the gap before the next pulse. The external-clock path is tested separately. The bench drives an exact number of slow edges and reads the count once the counter is stopped.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 5;
  localparam int PLEN_W  = 8;

  localparam logic [DATA_W-1:0] RELOAD_RST  = 32'h03EF_1480;
  localparam logic [PLEN_W-1:0] PLEN_RST    = 8'hFF;
  localparam logic [DATA_W-1:0] RESTART_KEY = 32'h0000_5AB9;

  typedef enum logic [2:0] {
    IDX_COUNT   = 3'd0,
    IDX_RELOAD  = 3'd1,
    IDX_RESTART = 3'd2,
    IDX_CTRL    = 3'd3,
    IDX_STATUS  = 3'd4,
    IDX_CLEAR   = 3'd5,
    IDX_PLEN    = 3'd6
  } reg_idx_e;

  // bit 0 run, 1 reset out, 2 irq out, 3 ext signal out, 4 clock select
  typedef struct packed {
    logic clk_sel;
    logic sig_en;
    logic irq_en;
    logic rst_en;
    logic run;
  } ctrl_t;

  localparam int CTRL_W  = $bits(ctrl_t);
  localparam int N_OUTS  = 3;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int                DW       = DATA_W,
  parameter int                AW       = ADDR_W,
  parameter int                PW       = PLEN_W,
  parameter logic [DW-1:0]     RLD_INIT = RELOAD_RST,
  parameter logic [PW-1:0]     PL_INIT  = PLEN_RST
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  input  logic [DW-1:0] count_i,
  input  logic          status_i,
  output logic [DW-1:0] reload_o,
  output logic [PW-1:0] plen_o,
  output ctrl_t         ctrl_o,
  output logic          restart_o,
  output logic          clear_o
);
  localparam int IW = AW - 2;

  logic          wr_en;
  logic [IW-1:0] idx;
  logic [DW-1:0] reload_q, reload_d;
  logic [PW-1:0] plen_q, plen_d;
  ctrl_t         ctrl_q, ctrl_d;

  assign wr_en = psel & penable & pwrite;
  assign idx   = paddr[AW-1:2];

  always_comb begin
    reload_d  = reload_q;
    plen_d    = plen_q;
    ctrl_d    = ctrl_q;
    restart_o = 1'b0;
    clear_o   = 1'b0;
    if (wr_en) begin
      unique case (idx)
        IW'(IDX_RELOAD):  reload_d  = pwdata;
        IW'(IDX_RESTART): restart_o = (pwdata == RESTART_KEY);
        IW'(IDX_CTRL):    ctrl_d    = ctrl_t'(pwdata[CTRL_W-1:0]);
        IW'(IDX_CLEAR):   clear_o   = pwdata[0];
        IW'(IDX_PLEN):    plen_d    = pwdata[PW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      reload_q <= RLD_INIT;
      plen_q   <= PL_INIT;
      ctrl_q   <= '0;
    end else if (wr_en) begin
      reload_q <= reload_d;
      plen_q   <= plen_d;
      ctrl_q   <= ctrl_d;
    end
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      unique case (idx)
        IW'(IDX_COUNT):  prdata = count_i;
        IW'(IDX_RELOAD): prdata = reload_q;
        IW'(IDX_CTRL):   prdata = DW'(ctrl_q);
        IW'(IDX_STATUS): prdata = DW'(status_i);
        IW'(IDX_PLEN):   prdata = DW'(plen_q);
        default:         prdata = '0;
      endcase
    end
  end

  assign reload_o = reload_q;
  assign plen_o   = plen_q;
  assign ctrl_o   = ctrl_q;
endmodule

// File: rtl/wdog_tick_sync.sv
module wdog_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic pclk,
  input  logic presetn,
  input  logic ext_i,
  input  logic sel_ext_i,
  output logic tick_o,
  output logic ext_edge_o
);
  logic [STAGES:0] pipe_q, pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-1:0], ext_i};
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) pipe_q <= '0;
    else          pipe_q <= pipe_d;
  end

  assign ext_edge_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign tick_o     = sel_ext_i ? ext_edge_o : 1'b1;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int            CW       = 32,
  parameter logic [CW-1:0] CNT_INIT = '0
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          restart_i,
  input  logic          clear_i,
  input  logic [CW-1:0] reload_i,
  output logic [CW-1:0] count_o,
  output logic          status_o,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          status_q, status_d;
  logic          step;
  logic          cnt_ce;

  assign step     = run_i & tick_i;
  assign expire_o = step & (cnt_q == '0);
  assign cnt_ce   = restart_i | step;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i || expire_o) cnt_d = reload_i;
    else if (step)             cnt_d = cnt_q - 1'b1;
  end

  always_comb begin
    status_d = status_q;
    if (expire_o)     status_d = 1'b1;
    else if (clear_i) status_d = 1'b0;
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)    cnt_q <= CNT_INIT;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) status_q <= 1'b0;
    else          status_q <= status_d;
  end

  assign count_o  = cnt_q;
  assign status_o = status_q;
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PW = 8,
  parameter int NO = 3
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          run_i,
  input  logic          expire_i,
  input  logic [PW-1:0] plen_i,
  input  logic [NO-1:0] out_en_i,
  output logic [NO-1:0] out_o
);
  logic          active_q, active_d;
  logic [PW-1:0] left_q, left_d;

  always_comb begin
    active_d = active_q;
    left_d   = left_q;
    if (!run_i) begin
      active_d = 1'b0;
      left_d   = '0;
    end else if (expire_i) begin
      active_d = 1'b1;
      left_d   = plen_i;
    end else if (active_q) begin
      if (left_q == '0) active_d = 1'b0;
      else              left_d   = left_q - 1'b1;
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      active_q <= 1'b0;
      left_q   <= '0;
    end else begin
      active_q <= active_d;
      left_q   <= left_d;
    end
  end

  for (genvar g = 0; g < NO; g++) begin : g_out
    assign out_o[g] = active_q & run_i & out_en_i[g];
  end
endmodule

// File: rtl/wdog_apb_top.sv
module wdog_apb_top
  import wdog_pkg::*;
(
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              ext_clk,
  output logic              wdog_reset_o,
  output logic              wdog_irq_o,
  output logic              wdog_sig_o
);
  logic [DATA_W-1:0] count, reload;
  logic [PLEN_W-1:0] plen;
  ctrl_t             ctrl_q;
  logic              restart_wr, clear_wr, status, expire, tick, ext_edge;
  logic [N_OUTS-1:0] outs, out_en;

  wdog_regs u_regs (
    .pclk, .presetn, .psel, .penable, .pwrite, .paddr, .pwdata, .prdata,
    .count_i(count), .status_i(status), .reload_o(reload), .plen_o(plen),
    .ctrl_o(ctrl_q), .restart_o(restart_wr), .clear_o(clear_wr)
  );

  wdog_tick_sync #(.STAGES(2)) u_sync (
    .pclk, .presetn, .ext_i(ext_clk), .sel_ext_i(ctrl_q.clk_sel),
    .tick_o(tick), .ext_edge_o(ext_edge)
  );

  wdog_counter #(.CW(DATA_W), .CNT_INIT(RELOAD_RST)) u_cnt (
    .pclk, .presetn, .run_i(ctrl_q.run), .tick_i(tick),
    .restart_i(restart_wr), .clear_i(clear_wr), .reload_i(reload),
    .count_o(count), .status_o(status), .expire_o(expire)
  );

  assign out_en = {ctrl_q.sig_en, ctrl_q.irq_en, ctrl_q.rst_en};

  wdog_pulse #(.PW(PLEN_W), .NO(N_OUTS)) u_pulse (
    .pclk, .presetn, .run_i(ctrl_q.run), .expire_i(expire),
    .plen_i(plen), .out_en_i(out_en), .out_o(outs)
  );

  assign wdog_reset_o = outs[0];
  assign wdog_irq_o   = outs[1];
  assign wdog_sig_o   = outs[2];
endmodule

// File: rtl/wdog_apb_chk.sv
module wdog_apb_chk (
  input logic        pclk,
  input logic        presetn,
  input logic        run,
  input logic        tick,
  input logic        ext_edge,
  input logic        restart_wr,
  input logic        clear_wr,
  input logic        status,
  input logic [31:0] count,
  input logic [31:0] reload,
  input logic        o_rst,
  input logic        o_irq,
  input logic        o_sig
);
  // R2
  a_r2_step_down: assert property (@(posedge pclk) disable iff (!presetn)
    (run && tick && count != 32'd0 && !restart_wr) |=> count == $past(count) - 32'd1);
  // R3
  a_r3_key_loads: assert property (@(posedge pclk) disable iff (!presetn)
    restart_wr |=> count == $past(reload));
  // R4
  a_r4_status_sticky: assert property (@(posedge pclk) disable iff (!presetn)
    (status && !clear_wr) |=> status);
  // R7
  a_r7_freeze: assert property (@(posedge pclk) disable iff (!presetn)
    (!run && !restart_wr) |=> $stable(count));
  // R7
  a_r7_quiet_off: assert property (@(posedge pclk) disable iff (!presetn)
    !run |-> !(o_rst || o_irq || o_sig));
  // R8
  a_r8_single_edge: assert property (@(posedge pclk) disable iff (!presetn)
    ext_edge |=> !ext_edge);
endmodule

bind wdog_apb_top wdog_apb_chk chk_i (
  .pclk(pclk), .presetn(presetn), .run(ctrl_q.run), .tick(tick),
  .ext_edge(ext_edge), .restart_wr(restart_wr), .clear_wr(clear_wr),
  .status(status), .count(count), .reload(reload),
  .o_rst(wdog_reset_o), .o_irq(wdog_irq_o), .o_sig(wdog_sig_o)
);

// File: tb/wdog_apb_top_tb_top.sv
module wdog_apb_top_tb_top;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [4:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        ext_clk = 1'b0;
  logic        o_rst, o_irq, o_sig;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 pclk = ~pclk;

  wdog_apb_top dut_i (
    .pclk, .presetn, .psel, .penable, .pwrite, .paddr, .pwdata, .prdata,
    .ext_clk, .wdog_reset_o(o_rst), .wdog_irq_o(o_irq), .wdog_sig_o(o_sig)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(posedge pclk);
    @(negedge pclk);
    penable = 1;
    @(posedge pclk);
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1; pwrite = 0; paddr = a;
    @(posedge pclk);
    @(negedge pclk);
    penable = 1;
    #1 d = prdata;
    @(posedge pclk);
    @(negedge pclk);
    psel = 0; penable = 0;
  endtask

  task automatic ext_pulse();
    @(negedge pclk); ext_clk = 1;
    repeat (4) @(negedge pclk);
    ext_clk = 0;
    repeat (4) @(negedge pclk);
  endtask

  initial begin
    logic [31:0] v, v2;
    int n, w;
    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);

    // R1 reset values
    bus_rd(5'h04, v); check("R1 reload", v, 32'h03EF1480);
    bus_rd(5'h00, v); check("R1 count", v, 32'h03EF1480);
    bus_rd(5'h18, v); check("R1 plen", v, 32'hFF);
    bus_rd(5'h0C, v); check("R1 ctrl", v, 0);
    bus_rd(5'h10, v); check("R1 status", v, 0);
    check("R1 outputs", {o_rst, o_irq, o_sig}, 0);

    // R9 readback
    bus_wr(5'h18, 32'h5A); bus_rd(5'h18, v); check("R9 plen", v, 32'h5A);
    bus_wr(5'h04, 32'hCAFE0123); bus_rd(5'h04, v); check("R9 reload", v, 32'hCAFE0123);
    bus_wr(5'h0C, 32'h1E); bus_rd(5'h0C, v); check("R9 ctrl", v, 32'h1E);
    bus_wr(5'h0C, 0);

    // R2 R5 R6 sweep: reload r, pulse length p < r
    for (int r = 1; r <= 6; r++) begin
      for (int p = 0; p < r; p++) begin
        bus_wr(5'h0C, 0);
        bus_wr(5'h04, r);
        bus_wr(5'h18, p);
        bus_wr(5'h08, 32'h5AB9);
        bus_wr(5'h14, 1);
        bus_wr(5'h0C, 32'h0F);
        n = 1;
        while (!o_irq && n < 100) begin @(negedge pclk); n++; end
        check("R2 expiry delay", n, r + 2);
        check("R6 all enabled", {o_rst, o_sig}, 2'b11);
        w = 0;
        while (o_irq && w < 300) begin w++; @(negedge pclk); end
        check("R5 pulse width", w, p + 1);
        n = 0;
        while (!o_irq && n < 100) begin n++; @(negedge pclk); end
        check("R5 periodic gap", n, r - p);
      end
    end
    bus_rd(5'h10, v); check("R4 status set", v, 1);

    // R4 clear semantics
    bus_wr(5'h0C, 0);
    bus_wr(5'h14, 0); bus_rd(5'h10, v); check("R4 clear bit0=0 ignored", v, 1);
    bus_wr(5'h14, 1); bus_rd(5'h10, v); check("R4 cleared", v, 0);

    // R6 only interrupt enabled
    bus_wr(5'h04, 3); bus_wr(5'h18, 2); bus_wr(5'h08, 32'h5AB9);
    bus_wr(5'h0C, 32'h05);
    n = 0;
    while (!o_irq && n < 100) begin n++; @(negedge pclk); end
    check("R6 irq fires", o_irq, 1);
    check("R6 reset/sig stay low", {o_rst, o_sig}, 0);

    // R7 disable during pulse
    bus_wr(5'h18, 8'hFF); bus_wr(5'h0C, 32'h0F);
    n = 0;
    while (!o_irq && n < 100) begin n++; @(negedge pclk); end
    bus_wr(5'h0C, 0);
    check("R7 outputs dropped", {o_rst, o_irq, o_sig}, 0);
    bus_rd(5'h00, v);
    repeat (10) @(negedge pclk);
    bus_rd(5'h00, v2); check("R7 frozen count", v2, v);

    // R3 key handling
    bus_wr(5'h08, 32'h5AB8); bus_rd(5'h00, v2); check("R3 wrong key ignored", v2, v);
    bus_wr(5'h08, 32'h15AB9); bus_rd(5'h00, v2); check("R3 wide wrong key ignored", v2, v);
    bus_wr(5'h04, 32'h1234); bus_wr(5'h08, 32'h5AB9);
    bus_rd(5'h00, v); check("R3 key loads reload", v, 32'h1234);

    // R8 external clock source
    bus_wr(5'h04, 10); bus_wr(5'h08, 32'h5AB9);
    bus_wr(5'h0C, 32'h11);
    repeat (20) @(negedge pclk);
    bus_rd(5'h00, v); check("R8 no ext edge no count", v, 10);
    ext_pulse(); ext_pulse(); ext_pulse();
    repeat (5) @(negedge pclk);
    bus_rd(5'h00, v); check("R8 three ext edges", v, 7);
    bus_wr(5'h0C, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge pclk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule